// File: doc/BRIEF.md
# Multi-width accumulator add/subtract unit

This execution unit performs addition and subtraction on an accumulator at three operand widths: byte, word and long. A byte is a quarter of the accumulator, a word is half of it, and a long is the full width. The accumulator is viewed as an upper half and a lower half. The second operand comes from one of three places: an external operand (register or memory, fetched elsewhere), an immediate, or the accumulator itself. In the last case the upper half is combined with the lower half. Byte and word forms may take a carry or borrow in. Byte forms may also run in packed-BCD mode, which produces a valid decimal result and a decimal carry.

A one-cycle start pulse launches an operation. On the following clock edge the unit presents a registered result together with the N, Z, V and C flags. In the same cycle it raises exactly one write-enable: one for the accumulator, or one for the external destination. When the external destination is memory, it also raises a read-modify-write indication. Operand fetch, addressing and the other status bits belong to neighbouring logic.

Top module: `acc_au_top`

## Requirements
- R1: While rst_ni is low, and after it rises until the first start, valid_o, acc_we_o, ext_we_o, rmw_o, all four flags and result_o are zero.
- R2: A start_i pulse sampled at a rising edge makes valid_o high for exactly the next cycle. Without start_i, result_o and the flags hold their last values and all write-enables stay low.
- R3: width_i selects the operand width: 0 is byte (ACC_W/4 bits), 1 is word (ACC_W/2 bits), and 2 or 3 is long (ACC_W bits). The result is computed modulo 2^width and zero-extended to ACC_W bits on result_o. With sub_i low the unit adds; with sub_i high it subtracts. src_i = 0 takes the second operand from ext_i and src_i = 1 takes it from imm_i. In both cases the accumulator is the first operand.
- R4: carry_i enters the operation only when carry_use_i is high and the width is byte or word. At long width, carry_i is ignored.
- R5: src_i = 2 or 3 (self mode) computes AH op AL. AH is the upper half of acc_i and AL is the lower half, each truncated to the selected width. The result always goes to the accumulator, even when dst_ext_i is high.
- R6: decimal_i at byte width treats both operands as packed BCD and always uses carry_i as the carry or borrow in. On add, each digit above 9 is corrected by +6. On subtract, each digit that borrowed is corrected by -6. C is the decimal carry or borrow out, and V is taken from the binary result.
- R7: n_o is the most significant bit of the result at the selected width. z_o is set when all result bits at that width are zero.
- R8: On add, c_o is the carry out of the width. On subtract, c_o is set when a borrow occurs, meaning the unsigned minuend is less than the subtrahend plus the borrow in. v_o is set on signed two's-complement overflow at the width.
- R9: With dst_ext_i high (not self mode), the operation is ext_i op acc_i and ext_we_o pulses with valid_o while acc_we_o stays low. Otherwise acc_we_o pulses. The two are never high together.
- R10: rmw_o pulses together with ext_we_o when dst_mem_i is high, and never without ext_we_o.
- R11: decimal_i has no effect at word or long width. Those operations are binary, and carry_i is used only if carry_use_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle operation launch |
| width_i | input | 2 | 0 byte, 1 word, 2/3 long |
| sub_i | input | 1 | 1 subtract, 0 add |
| carry_use_i | input | 1 | Use carry_i as carry/borrow in |
| decimal_i | input | 1 | Packed-BCD mode (byte only) |
| src_i | input | 2 | 0 external, 1 immediate, 2/3 accumulator halves |
| dst_ext_i | input | 1 | Destination is the external operand |
| dst_mem_i | input | 1 | External destination is memory |
| carry_i | input | 1 | Current carry flag |
| acc_i | input | ACC_W | Accumulator value |
| ext_i | input | ACC_W | External operand |
| imm_i | input | ACC_W | Immediate operand |
| valid_o | output | 1 | Result strobe |
| result_o | output | ACC_W | Zero-extended result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry/borrow flag |
| acc_we_o | output | 1 | Accumulator write-enable |
| ext_we_o | output | 1 | External destination write-enable |
| rmw_o | output | 1 | Read-modify-write indication |

## Verification
The bench builds the unit with the default ACC_W of 32, so byte, word and long are 8, 16 and 32 bits and each accumulator half is 16 bits. At this size, carry wrap and signed overflow can be provoked at every width. Self mode can also be shown truncating the 16-bit halves to a byte, with a nonzero upper half byte that must not leak into the result. Decimal vectors are chosen so that both digits need correction, including a carry that ripples from the low digit and out of the high digit.

// File: rtl/acc_au_pkg.sv
package acc_au_pkg;
  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_WORD = 2'd1,
    WID_LONG = 2'd2
  } wid_e;

  localparam int NUM_WID = 3;
endpackage

// File: rtl/acc_au_opsel.sv
module acc_au_opsel #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] ext_i,
  input  logic [ACC_W-1:0] imm_i,
  input  logic             self_i,
  input  logic             dst_ext_i,
  input  logic             src_imm_i,
  output logic [ACC_W-1:0] op_a_o,
  output logic [ACC_W-1:0] op_b_o
);
  localparam int HALF_W = ACC_W / 2;

  always_comb begin
    if (self_i) begin
      op_a_o = ACC_W'(acc_i[ACC_W-1:HALF_W]);
      op_b_o = ACC_W'(acc_i[HALF_W-1:0]);
    end else if (dst_ext_i) begin
      // destination operand is the minuend / first addend
      op_a_o = ext_i;
      op_b_o = acc_i;
    end else begin
      op_a_o = acc_i;
      op_b_o = src_imm_i ? imm_i : ext_i;
    end
  end
endmodule

// File: rtl/acc_au_binalu.sv
module acc_au_binalu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W:0] full;

  always_comb begin
    if (sub_i) full = {1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin_i);
    else       full = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
    res_o = full[W-1:0];
    c_o   = full[W];
    if (sub_i) v_o = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
    else       v_o = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/acc_au_bcd.sv
module acc_au_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int NIB = W / 4;

  logic       k;
  logic [4:0] d;

  // digit-serial ripple, corrected per digit
  always_comb begin
    k     = cin_i;
    d     = '0;
    res_o = '0;
    for (int i = 0; i < NIB; i++) begin
      if (sub_i) begin
        d = {1'b0, a_i[4*i +: 4]} - {1'b0, b_i[4*i +: 4]} - 5'(k);
        k = d[4];
        if (k) d = d - 5'd6;
      end else begin
        d = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + 5'(k);
        k = (d > 5'd9);
        if (k) d = d + 5'd6;
      end
      res_o[4*i +: 4] = d[3:0];
    end
    c_o = k;
  end
endmodule

// File: rtl/acc_au_top.sv
module acc_au_top #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       width_i,
  input  logic             sub_i,
  input  logic             carry_use_i,
  input  logic             decimal_i,
  input  logic [1:0]       src_i,
  input  logic             dst_ext_i,
  input  logic             dst_mem_i,
  input  logic             carry_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] ext_i,
  input  logic [ACC_W-1:0] imm_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] result_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o,
  output logic             acc_we_o,
  output logic             ext_we_o,
  output logic             rmw_o
);
  import acc_au_pkg::*;

  localparam int BYTE_W = ACC_W / 4;

  logic             self_mode, dst_ext_eff, is_long, is_byte, dec_eff, cin_eff;
  logic [1:0]       widx;
  logic [ACC_W-1:0] op_a, op_b;

  assign self_mode   = src_i[1];
  assign dst_ext_eff = dst_ext_i & ~self_mode;
  assign is_byte     = (width_i == WID_BYTE);
  assign is_long     = width_i[1];
  assign widx        = is_long ? 2'd2 : width_i;
  assign dec_eff     = decimal_i & is_byte;
  assign cin_eff     = carry_i & (carry_use_i | dec_eff) & ~is_long;

  acc_au_opsel #(.ACC_W(ACC_W)) u_opsel (
    .acc_i     (acc_i),
    .ext_i     (ext_i),
    .imm_i     (imm_i),
    .self_i    (self_mode),
    .dst_ext_i (dst_ext_eff),
    .src_imm_i (src_i[0]),
    .op_a_o    (op_a),
    .op_b_o    (op_b)
  );

  logic [ACC_W-1:0] res_w [NUM_WID];
  logic             c_w   [NUM_WID];
  logic             v_w   [NUM_WID];
  logic             n_w   [NUM_WID];

  for (genvar g = 0; g < NUM_WID; g++) begin : g_wid
    localparam int W = BYTE_W << g;
    logic [W-1:0] r;
    acc_au_binalu #(.W(W)) u_alu (
      .a_i   (op_a[W-1:0]),
      .b_i   (op_b[W-1:0]),
      .sub_i (sub_i),
      .cin_i (cin_eff),
      .res_o (r),
      .c_o   (c_w[g]),
      .v_o   (v_w[g])
    );
    assign res_w[g] = ACC_W'(r);
    assign n_w[g]   = r[W-1];
  end

  logic [BYTE_W-1:0] bcd_res;
  logic              bcd_c;

  acc_au_bcd #(.W(BYTE_W)) u_bcd (
    .a_i   (op_a[BYTE_W-1:0]),
    .b_i   (op_b[BYTE_W-1:0]),
    .sub_i (sub_i),
    .cin_i (cin_eff),
    .res_o (bcd_res),
    .c_o   (bcd_c)
  );

  logic [ACC_W-1:0] res_d;
  logic             n_d, c_d;

  always_comb begin
    if (dec_eff) begin
      res_d = ACC_W'(bcd_res);
      n_d   = bcd_res[BYTE_W-1];
      c_d   = bcd_c;
    end else begin
      res_d = res_w[widx];
      n_d   = n_w[widx];
      c_d   = c_w[widx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      n_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      c_o      <= 1'b0;
      acc_we_o <= 1'b0;
      ext_we_o <= 1'b0;
      rmw_o    <= 1'b0;
    end else begin
      valid_o  <= start_i;
      acc_we_o <= start_i & ~dst_ext_eff;
      ext_we_o <= start_i & dst_ext_eff;
      rmw_o    <= start_i & dst_ext_eff & dst_mem_i;
      if (start_i) begin
        result_o <= res_d;
        n_o      <= n_d;
        z_o      <= (res_d == '0);
        v_o      <= v_w[widx];
        c_o      <= c_d;
      end
    end
  end
endmodule

// File: rtl/acc_au_chk.sv
module acc_au_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       width_i,
  input logic [1:0]       src_i,
  input logic             valid_o,
  input logic [ACC_W-1:0] result_o,
  input logic             n_o,
  input logic             z_o,
  input logic             acc_we_o,
  input logic             ext_we_o,
  input logic             rmw_o
);
  localparam int BYTE_W = ACC_W / 4;

  assert_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);
  assert_no_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!valid_o && $stable(result_o) && !acc_we_o && !ext_we_o));
  assert_zero_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && width_i == 2'd0) |=> (result_o[ACC_W-1:BYTE_W] == '0));
  assert_self_to_acc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && src_i[1]) |=> (acc_we_o && !ext_we_o));
  assert_zero_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (z_o == (result_o == '0)));
  assert_byte_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && width_i == 2'd0) |=> (n_o == result_o[BYTE_W-1]));
  assert_we_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (acc_we_o != ext_we_o));
  assert_rmw_with_we_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rmw_o |-> ext_we_o);
endmodule

bind acc_au_top acc_au_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .width_i  (width_i),
  .src_i    (src_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .n_o      (n_o),
  .z_o      (z_o),
  .acc_we_o (acc_we_o),
  .ext_we_o (ext_we_o),
  .rmw_o    (rmw_o)
);

// File: tb/tb_acc_au_top.sv
module tb_acc_au_top;
  localparam int ACC_W = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       width_i = '0;
  logic             sub_i = 1'b0;
  logic             carry_use_i = 1'b0;
  logic             decimal_i = 1'b0;
  logic [1:0]       src_i = '0;
  logic             dst_ext_i = 1'b0;
  logic             dst_mem_i = 1'b0;
  logic             carry_i = 1'b0;
  logic [ACC_W-1:0] acc_i = '0;
  logic [ACC_W-1:0] ext_i = '0;
  logic [ACC_W-1:0] imm_i = '0;
  logic             valid_o, n_o, z_o, v_o, c_o, acc_we_o, ext_we_o, rmw_o;
  logic [ACC_W-1:0] result_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  acc_au_top #(.ACC_W(ACC_W)) dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // w sub cu dec src de dm cin acc ext imm | exp result, {n,z,v,c}, {acc_we,ext_we,rmw}
  task automatic run_op(input string tag, input logic [1:0] w, input logic s, input logic cu,
                        input logic dec, input logic [1:0] src, input logic de, input logic dm,
                        input logic cin, input logic [31:0] acc, input logic [31:0] ext,
                        input logic [31:0] imm, input logic [31:0] exp_res,
                        input logic [3:0] exp_f, input logic [2:0] exp_we);
    @(negedge clk_i);
    width_i = w; sub_i = s; carry_use_i = cu; decimal_i = dec; src_i = src;
    dst_ext_i = de; dst_mem_i = dm; carry_i = cin; acc_i = acc; ext_i = ext; imm_i = imm;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({tag, " valid"}, 64'(valid_o), 64'd1);
    check({tag, " result"}, 64'(result_o), 64'(exp_res));
    check({tag, " nzvc"}, 64'({n_o, z_o, v_o, c_o}), 64'(exp_f));
    check({tag, " we"}, 64'({acc_we_o, ext_we_o, rmw_o}), 64'(exp_we));
  endtask

  task automatic t_reset;
    check("R1 reset outs", 64'({valid_o, n_o, z_o, v_o, c_o, acc_we_o, ext_we_o, rmw_o}), 64'd0);
    check("R1 reset result", 64'(result_o), 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post-reset outs", 64'({valid_o, acc_we_o, ext_we_o, rmw_o}), 64'd0);
  endtask

  task automatic t_binary;
    run_op("R3 byte add ext", 0,0,0,0, 0,0,0,0, 32'h1234_5670, 32'h95, 0, 32'h05, 4'b0001, 3'b100);
    run_op("R8 byte add imm ovf", 0,0,0,0, 1,0,0,0, 32'h7F, 0, 32'h01, 32'h80, 4'b1010, 3'b100);
    run_op("R8 byte sub borrow", 0,1,0,0, 0,0,0,0, 32'h10, 32'h20, 0, 32'hF0, 4'b1001, 3'b100);
    run_op("R7 byte sub zero", 0,1,0,0, 0,0,0,0, 32'hFFFF_FF42, 32'h42, 0, 32'h0, 4'b0100, 3'b100);
    run_op("R7 word add wrap", 1,0,0,0, 0,0,0,0, 32'hAAAA_8000, 32'h8000, 0, 32'h0, 4'b0111, 3'b100);
    run_op("R8 long sub ovf", 2,1,0,0, 0,0,0,0, 32'h8000_0000, 32'h1, 0, 32'h7FFF_FFFF, 4'b0010, 3'b100);
  endtask

  task automatic t_carry;
    run_op("R4 word sub borrow-in", 1,1,1,0, 0,0,0,1, 32'h5, 32'h3, 0, 32'h1, 4'b0000, 3'b100);
    run_op("R4 long ignores carry", 2,0,1,0, 1,0,0,1, 32'hFFFF_FFFF, 0, 32'h1, 32'h0, 4'b0101, 3'b100);
    run_op("R4 byte carry unused", 0,0,0,0, 0,0,0,1, 32'h1, 32'h1, 0, 32'h2, 4'b0000, 3'b100);
  endtask

  task automatic t_self;
    run_op("R5 self byte addc", 0,0,1,0, 2,0,0,1, 32'h5512_0034, 0, 0, 32'h47, 4'b0000, 3'b100);
    run_op("R5 self word sub", 1,1,0,0, 2,1,1,0, 32'h0001_0002, 0, 0, 32'hFFFF, 4'b1001, 3'b100);
  endtask

  task automatic t_decimal;
    run_op("R6 bcd add", 0,0,0,1, 2,0,0,1, 32'h0045_0038, 0, 0, 32'h84, 4'b1000, 3'b100);
    run_op("R6 bcd add carry", 0,0,0,1, 2,0,0,0, 32'h0099_0001, 0, 0, 32'h00, 4'b0101, 3'b100);
    run_op("R6 bcd sub", 0,1,0,1, 2,0,0,1, 32'h0042_0017, 0, 0, 32'h24, 4'b0000, 3'b100);
    run_op("R6 bcd sub borrow", 0,1,0,1, 2,0,0,0, 32'h0005_0010, 0, 0, 32'h95, 4'b1001, 3'b100);
    run_op("R11 word ignores dec", 1,0,0,1, 0,0,0,1, 32'h9, 32'h1, 0, 32'hA, 4'b0000, 3'b100);
  endtask

  task automatic t_dest;
    run_op("R9 ext dest sub", 0,1,0,0, 0,1,0,0, 32'h20, 32'h50, 0, 32'h30, 4'b0000, 3'b010);
    run_op("R10 mem dest rmw", 1,0,0,0, 0,1,1,0, 32'h0001_1111, 32'h1234, 0, 32'h2345, 4'b0000, 3'b011);
  endtask

  task automatic t_hold;
    @(negedge clk_i);
    acc_i = 32'hDEAD_BEEF; ext_i = 32'h1; width_i = 2; src_i = 0;
    repeat (3) @(negedge clk_i);
    check("R2 idle valid/we", 64'({valid_o, acc_we_o, ext_we_o, rmw_o}), 64'd0);
    check("R2 idle result held", 64'(result_o), 64'h2345);
    check("R2 idle flags held", 64'({n_o, z_o, v_o, c_o}), 64'd0);
  endtask

  initial begin
    #1;
    t_reset();
    t_binary();
    t_carry();
    t_self();
    t_decimal();
    t_dest();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule